// File: doc/BRIEF.md
# Direct-Mapped Word-Valid Write-Through Data Cache

This block is a 256-byte data cache placed between a processor's word request port and a memory bus. It has 16 lines of four 32-bit words. The cache looks up every request with the address exactly as presented: there is no translation step. Each word in a line has its own valid bit, so a line can be partly valid. A read hit completes in the same cycle as the request. A read miss goes to memory in one of two ways. It fetches only the requested word, or, when the memory side reports that it can burst, it fetches the whole line in one wrapping burst. The burst starts at the requested word, and that word is handed to the processor as soon as it arrives.

Every write goes to memory, so the cache never holds dirty data. A write hit also updates the cached copy. A write miss changes nothing unless write-allocate is enabled. With write-allocate enabled, a write miss installs the written word into its line. A flush input drops every valid bit in a single cycle.

Top module: `sector_wt_cache`

## Requirements
- R1: The address is split as follows. Bits [3:2] select the word, bits [7:4] select one of 16 lines, and bits [31:8] form the tag. Addresses with the same index and different tags share a line and evict each other. Other indices are not affected.
- R2: A read hit needs a matching tag and the valid bit of the addressed word. It raises `cpu_done` in the request cycle with the cached word and starts no memory access.
- R3: If the tag matches but the addressed word is invalid, the read is a miss. A single-word refill of that word leaves the other valid words of the line valid.
- R4: While `mem_burst_ok` is low, a read miss issues one memory read of the requested word address with `mem_burst` low.
- R5: While `mem_burst_ok` is high, a read miss issues one burst read with `mem_burst` high. The burst holds `mem_req` and `mem_addr` until four acknowledged beats have arrived. The beats carry word offsets requested, requested+1, and so on, modulo 4. The first beat completes the CPU read while `mem_req` stays high, and afterwards all four words hit.
- R6: Every write issues one memory write (`mem_we` high, `mem_burst` low) with the request address and data. `cpu_done` rises on the memory acknowledge.
- R7: A write hit updates the cached word, so a later read hits and returns the new data.
- R8: With `wr_alloc_en` low, a write miss leaves the cache unchanged. The line's previous contents still hit, and the written address still misses.
- R9: With `wr_alloc_en` high, a write miss installs the written word as the only valid word of its line under the new tag.
- R10: When a new tag is written into a line, all of the line's valid bits are cleared before the fetched or written word is marked valid.
- R11: `flush_all` clears every valid bit in one cycle. If it falls in the same cycle as a refill beat, the flush wins for that word. The processor still receives the data, and later beats of a burst are installed.
- R12: After reset, no word is valid and `mem_req` and `cpu_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush_all | input | 1 | Clear all valid bits this cycle |
| wr_alloc_en | input | 1 | Write misses install the written word |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | 32 | Word-aligned byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_done` |
| mem_req | output | 1 | Memory transaction active |
| mem_we | output | 1 | Transaction is a write |
| mem_burst | output | 1 | Transaction is a four-beat wrapping read |
| mem_addr | output | 32 | Transaction address (critical word for bursts) |
| mem_wdata | output | 32 | Write data to memory |
| mem_burst_ok | input | 1 | Memory side supports burst reads |
| mem_ack | input | 1 | One beat or write completes |
| mem_rdata | input | 32 | Read beat data |

## Verification
A refill beat that marks a word valid and a `flush_all` that clears every valid bit can fall in the same cycle. The bench provokes this by raising the flush in exactly the cycle in which the memory model acknowledges a beat. It does this for a single-word refill and for the first beat of a burst. The outcome is judged at the ports. The processor must get the correct data. A re-read of the flushed word must start a new memory read. Words delivered by later burst beats must still hit.

// File: rtl/swc_pkg.sv
`timescale 1ns/1ps
package swc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_FILL  = 2'd2
  } swc_state_e;
endpackage

// File: rtl/swc_rst_sync.sv
`timescale 1ns/1ps
module swc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/swc_store.sv
`timescale 1ns/1ps
module swc_store #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               flush,
  input  logic [$clog2(LINES)-1:0]           lk_idx,
  input  logic [$clog2(WORDS)-1:0]           lk_off,
  output logic [ADDR_W-$clog2(LINES)-$clog2(WORDS)-3:0] lk_tag_o,
  output logic                               lk_any_o,
  output logic                               lk_vld_o,
  output logic [DATA_W-1:0]                  lk_data_o,
  input  logic                               inst_en,
  input  logic [ADDR_W-$clog2(LINES)-$clog2(WORDS)-3:0] inst_tag,
  input  logic                               wr_en,
  input  logic [$clog2(LINES)-1:0]           wr_idx,
  input  logic [$clog2(WORDS)-1:0]           wr_off,
  input  logic [DATA_W-1:0]                  wr_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFS_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W - 2;

  logic [TAG_W-1:0]  tag_q [LINES];
  logic [WORDS-1:0]  vld_q [LINES];
  logic [WORDS-1:0]  vld_d [LINES];
  logic [DATA_W-1:0] dat_q [LINES][WORDS];
  logic              any_vld;

  // valid next state: install clears, word write sets, flush overrides all
  always_comb begin
    for (int l = 0; l < LINES; l++) begin
      vld_d[l] = vld_q[l];
      if (inst_en && (wr_idx == IDX_W'(l))) vld_d[l] = '0;
      if (wr_en && (wr_idx == IDX_W'(l)))   vld_d[l][wr_off] = 1'b1;
      if (flush)                            vld_d[l] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) vld_q[l] <= '0;
    end else begin
      for (int l = 0; l < LINES; l++) vld_q[l] <= vld_d[l];
    end
  end

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[wr_idx] <= inst_tag;
  end

  always_ff @(posedge clk) begin
    if (wr_en) dat_q[wr_idx][wr_off] <= wr_data;
  end

  always_comb begin
    any_vld = 1'b0;
    for (int l = 0; l < LINES; l++) any_vld = any_vld | (|vld_q[l]);
  end

  assign lk_tag_o  = tag_q[lk_idx];
  assign lk_any_o  = |vld_q[lk_idx];
  assign lk_vld_o  = vld_q[lk_idx][lk_off];
  assign lk_data_o = dat_q[lk_idx][lk_off];

  assert_flush_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !any_vld);

  assert_install_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inst_en |=> ($countones(vld_q[$past(wr_idx)]) <= 1));
endmodule

// File: rtl/swc_ctrl.sv
`timescale 1ns/1ps
module swc_ctrl
  import swc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_alloc_en,
  input  logic                               cpu_req,
  input  logic                               cpu_we,
  input  logic [ADDR_W-1:0]                  cpu_addr,
  input  logic [DATA_W-1:0]                  cpu_wdata,
  output logic                               cpu_done,
  output logic [DATA_W-1:0]                  cpu_rdata,
  output logic                               mem_req,
  output logic                               mem_we,
  output logic                               mem_burst,
  output logic [ADDR_W-1:0]                  mem_addr,
  output logic [DATA_W-1:0]                  mem_wdata,
  input  logic                               mem_burst_ok,
  input  logic                               mem_ack,
  input  logic [DATA_W-1:0]                  mem_rdata,
  output logic [$clog2(LINES)-1:0]           lk_idx,
  output logic [$clog2(WORDS)-1:0]           lk_off,
  input  logic [ADDR_W-$clog2(LINES)-$clog2(WORDS)-3:0] lk_tag,
  input  logic                               lk_any,
  input  logic                               lk_vld,
  input  logic [DATA_W-1:0]                  lk_data,
  output logic                               inst_en,
  output logic [ADDR_W-$clog2(LINES)-$clog2(WORDS)-3:0] inst_tag,
  output logic                               wr_en,
  output logic [$clog2(LINES)-1:0]           wr_idx,
  output logic [$clog2(WORDS)-1:0]           wr_off,
  output logic [DATA_W-1:0]                  wr_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFS_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W - 2;
  localparam int WA_W  = ADDR_W - 2;
  localparam logic [OFS_W-1:0] LAST_BEAT = OFS_W'(WORDS - 1);

  swc_state_e        state_q, state_d;
  logic [WA_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              burst_q, burst_d;
  logic [OFS_W-1:0]  beat_q, beat_d;
  logic              owned, hit;

  assign lk_off   = cpu_addr[2 +: OFS_W];
  assign lk_idx   = cpu_addr[2+OFS_W +: IDX_W];
  assign inst_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  // a line belongs to the request only if it holds some valid word under its tag
  assign owned = lk_any && (lk_tag == inst_tag);
  assign hit   = owned && lk_vld;

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    wdata_d   = wdata_q;
    burst_d   = burst_q;
    beat_d    = beat_q;
    cpu_done  = 1'b0;
    cpu_rdata = '0;
    inst_en   = 1'b0;
    wr_en     = 1'b0;
    wr_idx    = addr_q[OFS_W +: IDX_W];
    wr_off    = addr_q[OFS_W-1:0] + beat_q;
    wr_data   = mem_rdata;
    unique case (state_q)
      ST_IDLE: begin
        wr_idx  = lk_idx;
        wr_off  = lk_off;
        wr_data = cpu_wdata;
        if (cpu_req) begin
          addr_d = cpu_addr[ADDR_W-1:2];
          if (cpu_we) begin
            wdata_d = cpu_wdata;
            state_d = ST_WRITE;
            wr_en   = hit || wr_alloc_en;
            inst_en = wr_alloc_en && !owned;
          end else if (hit) begin
            cpu_done  = 1'b1;
            cpu_rdata = lk_data;
          end else begin
            inst_en = !owned;
            burst_d = mem_burst_ok;
            beat_d  = '0;
            state_d = ST_FILL;
          end
        end
      end
      ST_WRITE: begin
        if (mem_ack) begin
          cpu_done = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          wr_en = 1'b1;
          if (beat_q == '0) begin
            cpu_done  = 1'b1;
            cpu_rdata = mem_rdata;
          end
          if (!burst_q || (beat_q == LAST_BEAT)) state_d = ST_IDLE;
          else                                   beat_d  = beat_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      burst_q <= 1'b0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      burst_q <= burst_d;
      beat_q  <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr_d;
    wdata_q <= wdata_d;
  end

  assign mem_req   = (state_q == ST_WRITE) || (state_q == ST_FILL);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_burst = (state_q == ST_FILL) && burst_q;
  assign mem_addr  = {addr_q, 2'b00};
  assign mem_wdata = wdata_q;

  assert_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> (cpu_addr[1:0] == 2'b00));

  assert_idle_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && !mem_req) |-> (cpu_req && !cpu_we));

  assert_single_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && !mem_burst) |-> (beat_q == '0));

  assert_hold_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_wr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_burst);
endmodule

// File: rtl/sector_wt_cache.sv
`timescale 1ns/1ps
module sector_wt_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_all,
  input  logic              wr_alloc_en,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_burst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_burst_ok,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFS_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W - 2;

  logic              rst_n_s;
  logic [IDX_W-1:0]  lk_idx, wr_idx;
  logic [OFS_W-1:0]  lk_off, wr_off;
  logic [TAG_W-1:0]  lk_tag, inst_tag;
  logic              lk_any, lk_vld, inst_en, wr_en;
  logic [DATA_W-1:0] lk_data, wr_data;

  swc_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  swc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) ctrl_i (
    .clk(clk), .rst_n(rst_n_s), .wr_alloc_en(wr_alloc_en),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_burst_ok(mem_burst_ok), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata),
    .lk_idx(lk_idx), .lk_off(lk_off), .lk_tag(lk_tag), .lk_any(lk_any),
    .lk_vld(lk_vld), .lk_data(lk_data),
    .inst_en(inst_en), .inst_tag(inst_tag), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_off(wr_off), .wr_data(wr_data)
  );

  swc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) store_i (
    .clk(clk), .rst_n(rst_n_s), .flush(flush_all),
    .lk_idx(lk_idx), .lk_off(lk_off), .lk_tag_o(lk_tag), .lk_any_o(lk_any),
    .lk_vld_o(lk_vld), .lk_data_o(lk_data),
    .inst_en(inst_en), .inst_tag(inst_tag), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_off(wr_off), .wr_data(wr_data)
  );
endmodule

// File: tb/sector_wt_cache_tb_top.sv
`timescale 1ns/1ps
module sector_wt_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_all, wr_alloc_en;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata;
  logic        cpu_done;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we, mem_burst;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_burst_ok, mem_ack;
  logic [31:0] mem_rdata;

  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_burst = 0, n_wr = 0;
  logic [31:0] last_rd_a, last_wr_a, last_wr_d;
  logic [31:0] store [int unsigned];
  bit finished = 0;

  always #2 clk = ~clk;

  sector_wt_cache dut_i (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all), .wr_alloc_en(wr_alloc_en),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_burst_ok(mem_burst_ok), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] mv(input logic [31:0] a);
    if (store.exists(a)) return store[a];
    return a ^ 32'hC0DE_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: one idle cycle, then one beat (or four wrapping beats)
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req === 1'b1) begin
        logic [31:0] a, d;
        bit w;
        int nb;
        a = mem_addr; w = mem_we; d = mem_wdata; nb = mem_burst ? 4 : 1;
        if (w) begin
          n_wr++; last_wr_a = a; last_wr_d = d;
        end else begin
          n_rd++; last_rd_a = a;
          if (nb == 4) n_burst++;
        end
        @(negedge clk);
        for (int i = 0; i < nb; i++) begin
          logic [31:0] ba;
          ba = {a[31:4], 2'(a[3:2] + i), 2'b00};
          mem_ack = 1'b1;
          if (w) store[a] = d;
          mem_rdata = w ? 32'h0 : mv(ba);
          @(negedge clk);
        end
        mem_ack = 1'b0;
      end
    end
  end

  task automatic cpu_read(input logic [31:0] a, input bit fl, output logic [31:0] d, output int cyc);
    bit got, flushed;
    got = 0; flushed = 0; cyc = 0; d = '0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    while (!got) begin
      #1;
      if (fl && !flushed && mem_ack) begin flush_all = 1'b1; flushed = 1; end
      if (cpu_done) begin got = 1; d = cpu_rdata; end
      @(negedge clk);
      flush_all = 1'b0;
      if (!got) cyc++;
    end
    cpu_req = 1'b0;
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [31:0] d);
    bit got;
    got = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    while (!got) begin
      #1;
      if (cpu_done) got = 1;
      @(negedge clk);
    end
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (8) @(negedge clk);
  endtask

  // read and judge hit (no new memory read, zero wait) or miss
  task automatic rd_expect(input logic [31:0] a, input bit exp_hit, input string req);
    logic [31:0] d;
    int cyc, r0;
    wait_idle();
    r0 = n_rd;
    cpu_read(a, 1'b0, d, cyc);
    wait_idle();
    chk(d == mv(a), req, d, mv(a));
    if (exp_hit) begin
      chk(n_rd == r0 && cyc == 0, {req, " hit"}, 32'(n_rd - r0), 32'h0);
    end else begin
      chk(n_rd == r0 + 1, {req, " miss"}, 32'(n_rd - r0), 32'h1);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; flush_all = 0; wr_alloc_en = 0; cpu_req = 0; cpu_we = 0;
    cpu_addr = '0; cpu_wdata = '0; mem_burst_ok = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(mem_req == 1'b0, "R12 mem_req in reset", 32'(mem_req), 32'h0);
    chk(cpu_done == 1'b0, "R12 cpu_done in reset", 32'(cpu_done), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(mem_req == 1'b0, "R12 mem_req after reset", 32'(mem_req), 32'h0);
    rd_expect(32'h0000_0100, 1'b0, "R12 empty after reset");
  endtask

  task automatic test_single();
    logic [31:0] d;
    int cyc, b0, r0;
    mem_burst_ok = 0;
    wait_idle();
    b0 = n_burst; r0 = n_rd;
    cpu_read(32'h0000_1004, 1'b0, d, cyc);
    wait_idle();
    chk(d == mv(32'h1004), "R4 single data", d, mv(32'h1004));
    chk(n_rd == r0 + 1, "R4 one read", 32'(n_rd - r0), 32'h1);
    chk(last_rd_a == 32'h1004, "R4 word address", last_rd_a, 32'h1004);
    chk(n_burst == b0, "R4 no burst", 32'(n_burst - b0), 32'h0);
    rd_expect(32'h0000_1004, 1'b1, "R2 read hit");
    rd_expect(32'h0000_1008, 1'b0, "R3 invalid word in owned line");
    rd_expect(32'h0000_1004, 1'b1, "R3 other word kept");
  endtask

  task automatic test_burst();
    logic [31:0] d;
    int cyc, b0;
    mem_burst_ok = 1;
    wait_idle();
    b0 = n_burst;
    cpu_read(32'h0000_200C, 1'b0, d, cyc);
    #1;
    chk(mem_req == 1'b1, "R5 critical word before fill end", 32'(mem_req), 32'h1);
    chk(d == mv(32'h200C), "R5 critical data", d, mv(32'h200C));
    wait_idle();
    chk(n_burst == b0 + 1, "R5 one burst", 32'(n_burst - b0), 32'h1);
    rd_expect(32'h0000_2000, 1'b1, "R5 wrapped word 0");
    rd_expect(32'h0000_2004, 1'b1, "R5 wrapped word 1");
    rd_expect(32'h0000_2008, 1'b1, "R5 wrapped word 2");
    mem_burst_ok = 0;
  endtask

  task automatic test_replace();
    mem_burst_ok = 0;
    rd_expect(32'h0000_3004, 1'b0, "R1 new tag misses");
    rd_expect(32'h0000_3008, 1'b0, "R10 other words cleared");
    rd_expect(32'h0000_1014, 1'b0, "R1 index 1 fill");
    rd_expect(32'h0000_1004, 1'b0, "R1 evicted tag misses");
    rd_expect(32'h0000_1014, 1'b1, "R1 other index kept");
  endtask

  task automatic test_write_hit();
    int w0;
    rd_expect(32'h0000_4040, 1'b0, "R7 prefill");
    w0 = n_wr;
    cpu_write(32'h0000_4040, 32'hDEAD_BEEF);
    wait_idle();
    chk(n_wr == w0 + 1, "R6 one write", 32'(n_wr - w0), 32'h1);
    chk(last_wr_a == 32'h4040, "R6 write address", last_wr_a, 32'h4040);
    chk(last_wr_d == 32'hDEAD_BEEF, "R6 write data", last_wr_d, 32'hDEAD_BEEF);
    rd_expect(32'h0000_4040, 1'b1, "R7 updated word");
  endtask

  task automatic test_write_noalloc();
    int w0;
    wr_alloc_en = 0;
    w0 = n_wr;
    cpu_write(32'h0000_5040, 32'h1234_5678);
    wait_idle();
    chk(n_wr == w0 + 1, "R6 miss written through", 32'(n_wr - w0), 32'h1);
    rd_expect(32'h0000_4040, 1'b1, "R8 line untouched");
    rd_expect(32'h0000_5040, 1'b0, "R8 not installed");
  endtask

  task automatic test_write_alloc();
    wr_alloc_en = 1;
    cpu_write(32'h0000_6024, 32'hCAFE_F00D);
    rd_expect(32'h0000_6024, 1'b1, "R9 allocated word hits");
    rd_expect(32'h0000_6028, 1'b0, "R9 neighbour invalid");
    wr_alloc_en = 0;
  endtask

  task automatic test_flush();
    wait_idle();
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
    rd_expect(32'h0000_6028, 1'b0, "R11 flushed word");
    rd_expect(32'h0000_6024, 1'b0, "R11 flushed word 2");
  endtask

  task automatic test_flush_fill();
    logic [31:0] d;
    int cyc;
    mem_burst_ok = 0;
    wait_idle();
    cpu_read(32'h0000_7050, 1'b1, d, cyc);
    chk(d == mv(32'h7050), "R11 data with flush", d, mv(32'h7050));
    rd_expect(32'h0000_7050, 1'b0, "R11 flush beats single fill");
    mem_burst_ok = 1;
    wait_idle();
    cpu_read(32'h0000_8064, 1'b1, d, cyc);
    chk(d == mv(32'h8064), "R11 burst data with flush", d, mv(32'h8064));
    rd_expect(32'h0000_8068, 1'b1, "R11 later beat installed");
    rd_expect(32'h0000_8064, 1'b0, "R11 flushed first beat");
    mem_burst_ok = 0;
  endtask

  initial begin
    test_reset();
    test_single();
    test_burst();
    test_replace();
    test_write_hit();
    test_write_noalloc();
    test_write_alloc();
    test_flush();
    test_flush_fill();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule